// File: doc/BRIEF.md
# SAR ADC conversion sequencer

This block is the digital controller of a 10-bit successive-approximation converter. It derives a conversion-clock enable from the system clock, or from a separate free-running RC clock. On a go strobe it opens the sample switch and waits for the first conversion-clock enable. It then spends one settle period and ten bit periods driving a trial word to an external DAC. In each bit period it keeps or drops the trial bit according to a comparator input. The analog comparator, the DAC and the reference selection sit outside the block.

When the last bit is decided, several things happen in one clock cycle: the result is written into a high and a low result register in the selected justification, the busy/go indication drops, the interrupt flag rises and the sample switch closes again. Software can abort a conversion by clearing go. It acknowledges the flag with a write-one-to-clear strobe.

The sequencer has four states. IDLE leaves the switch closed. ALIGN waits for the first conversion-clock enable. SETTLE is the first conversion-clock period. RESOLVE covers the ten bit periods. The transitions are:

- IDLE→ALIGN on a go strobe.
- ALIGN→SETTLE on an enable.
- SETTLE→RESOLVE on an enable, loading trial bit 9.
- RESOLVE→RESOLVE on an enable while bits remain.
- RESOLVE→IDLE on the enable that decides bit 0 (done).
- ALIGN/SETTLE/RESOLVE→IDLE on a go-clear strobe (abort).

Top module: `sar_conv_seq`

## Requirements
- R1: In divider mode the conversion-clock period P in system cycles is set by `clk_sel`: 3'b000→2, 3'b100→4, 3'b001→8, 3'b101→16, 3'b010→32, 3'b110→64.
- R2: When `clk_sel[1:0]` is 2'b11, the enables come from rising edges of `rc_clk`, taken through a two-flop synchronizer. With an RC period of R system cycles, P equals R.
- R3: After a go strobe is accepted, `go` is high for between 11·P+1 and 12·P system cycles. That is a sync delay of 1..P cycles followed by 11 conversion-clock periods.
- R4: `sample_en` is 0 in every cycle in which `go` is 1, and 1 otherwise.
- R5: Bits are resolved MSB first. Each bit is set as a trial in `dac_code` and kept when `cmp_in` is 1 (input ≥ DAC). With an ideal comparator the result equals the input code. `dac_code` is 0 whenever `go` is 0.
- R6: On completion, the result registers load, `go` falls, `irq_flag` rises and `sample_en` returns to 1, all in the same cycle.
- R7: With `right_just`=1 the 10-bit result r loads as `res_hi` = {6'b0, r[9:8]} and `res_lo` = r[7:0].
- R8: With `right_just`=0, r loads as `res_hi` = r[9:2] and `res_lo` = {r[1:0], 6'b0}.
- R9: A `go_clr` strobe during a conversion returns the block to idle in the next cycle. `res_hi` and `res_lo` keep their old contents, `irq_flag` stays 0 and `sample_en` returns to 1. `go_clr` wins over a simultaneous completion.
- R10: `irq_flag` stays 1 until a `flag_clr` strobe. A completion in the same cycle as `flag_clr` leaves it set.
- R11: A `go_set` strobe while `go` is 1 has no effect: the conversion neither restarts nor lengthens, and its result is unchanged.
- R12: After reset, `go`=0, `sample_en`=1, `irq_flag`=0, `dac_code`=0, `res_hi`=0 and `res_lo`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clk_sel | input | 3 | Conversion-clock select |
| rc_clk | input | 1 | Free-running RC clock, asynchronous |
| right_just | input | 1 | 1 = right-justified result, 0 = left-justified |
| go_set | input | 1 | Start strobe, one cycle |
| go_clr | input | 1 | Abort strobe, one cycle |
| flag_clr | input | 1 | Write-one-to-clear strobe for the flag |
| cmp_in | input | 1 | Comparator: 1 when input ≥ DAC |
| go | output | 1 | Conversion in progress |
| sample_en | output | 1 | Sample switch closed when 1 |
| dac_code | output | 10 | Trial word to the DAC |
| res_hi | output | 8 | High result register |
| res_lo | output | 8 | Low result register |
| irq_flag | output | 1 | Conversion-complete flag |

## Verification
On every cycle the checker enforces several cycle-level rules:

- the sample switch is the complement of go;
- the DAC word is zero when idle;
- the result registers change only in a completion cycle;
- the flag rises only when go falls without an abort, and clears only on a strobe;
- a completion always sets the flag.

Only the bench scenarios can show the rest. The converted value must equal the input across all 1024 codes. The justification layouts must be correct. Each select code must give its own conversion length. An abort, a late go strobe and a flag acknowledge must behave as specified.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;

    localparam int RES_W = 10;
    localparam int REG_W = 8;
    localparam int IDX_W = $clog2(RES_W);

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_ALIGN   = 2'd1,
        ST_SETTLE  = 2'd2,
        ST_RESOLVE = 2'd3
    } sar_state_e;

    // log2 of the divide ratio: low two select bits step by four, bit 2 doubles
    function automatic logic [2:0] div_shift(input logic [2:0] sel);
        return {sel[1:0], 1'b0} + 3'd1 + {2'b00, sel[2]};
    endfunction

    function automatic logic [6:0] div_term(input logic [2:0] sel);
        return (7'd1 << div_shift(sel)) - 7'd1;
    endfunction

    function automatic logic rc_selected(input logic [2:0] sel);
        return sel[1] & sel[0];
    endfunction

endpackage

// File: rtl/sar_tad_gen.sv
module sar_tad_gen
    import sar_seq_pkg::*;
#(
    parameter int DIV_W       = 6,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] sel,
    input  logic       rc_clk,
    output logic       tick
);

    localparam int HIST_W = SYNC_STAGES + 1;

    logic [DIV_W-1:0]  cnt_q;
    logic [DIV_W-1:0]  term;
    logic              rc_mode;
    logic              div_tick;
    logic              rc_rise;
    logic [HIST_W-1:0] rc_pipe_q;

    assign rc_mode  = rc_selected(sel);
    assign term     = DIV_W'(div_term(sel));
    assign div_tick = (cnt_q >= term);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (rc_mode || div_tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // synchronizer chain plus one history flop for edge detection
    generate
        for (genvar g = 0; g < HIST_W; g++) begin : g_rc_pipe
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) rc_pipe_q[g] <= 1'b0;
                    else        rc_pipe_q[g] <= rc_clk;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) rc_pipe_q[g] <= 1'b0;
                    else        rc_pipe_q[g] <= rc_pipe_q[g-1];
                end
            end
        end
    endgenerate

    assign rc_rise = rc_pipe_q[SYNC_STAGES-1] & ~rc_pipe_q[SYNC_STAGES];
    assign tick    = rc_mode ? rc_rise : div_tick;

endmodule

// File: rtl/sar_fsm.sv
module sar_fsm
    import sar_seq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             go_set,
    input  logic             go_clr,
    input  logic             cmp_in,
    output logic             busy,
    output logic             sample_en,
    output logic [RES_W-1:0] dac_code,
    output logic             load,
    output logic [RES_W-1:0] load_data
);

    sar_state_e       state_q, state_d;
    logic [IDX_W-1:0] idx_q;
    logic [RES_W-1:0] sar_q;
    logic             last_bit;
    logic             enter_resolve;
    logic             bit_step;

    assign last_bit = (idx_q == '0);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (go_set && !go_clr) state_d = ST_ALIGN;
            ST_ALIGN:   if (go_clr) state_d = ST_IDLE;
                        else if (tick) state_d = ST_SETTLE;
            ST_SETTLE:  if (go_clr) state_d = ST_IDLE;
                        else if (tick) state_d = ST_RESOLVE;
            ST_RESOLVE: if (go_clr) state_d = ST_IDLE;
                        else if (tick && last_bit) state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    assign enter_resolve = (state_q == ST_SETTLE) && tick && !go_clr;
    assign bit_step      = (state_q == ST_RESOLVE) && tick && !go_clr;

    // trial register: current trial bit set, lower bits zero, upper bits decided
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sar_q <= '0;
            idx_q <= '0;
        end else if (state_d == ST_IDLE) begin
            sar_q <= '0;
            idx_q <= '0;
        end else if (enter_resolve) begin
            sar_q <= RES_W'(1) << (RES_W - 1);
            idx_q <= IDX_W'(RES_W - 1);
        end else if (bit_step) begin
            sar_q[idx_q] <= cmp_in;
            if (!last_bit) begin
                sar_q[idx_q - 1'b1] <= 1'b1;
                idx_q <= idx_q - 1'b1;
            end
        end
    end

    always_comb begin
        busy      = (state_q != ST_IDLE);
        sample_en = (state_q == ST_IDLE);
        dac_code  = sar_q;
        load      = bit_step && last_bit;
        load_data = {sar_q[RES_W-1:1], cmp_in};
    end

endmodule

// File: rtl/sar_result_fmt.sv
module sar_result_fmt
    import sar_seq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [RES_W-1:0] load_data,
    input  logic             right_just,
    input  logic             flag_clr,
    output logic [REG_W-1:0] res_hi,
    output logic [REG_W-1:0] res_lo,
    output logic             irq_flag
);

    localparam int SPILL = RES_W - REG_W;

    logic [REG_W-1:0] hi_d, lo_d;

    always_comb begin
        if (right_just) begin
            hi_d = {{(REG_W-SPILL){1'b0}}, load_data[RES_W-1:REG_W]};
            lo_d = load_data[REG_W-1:0];
        end else begin
            hi_d = load_data[RES_W-1:SPILL];
            lo_d = {load_data[SPILL-1:0], {(REG_W-SPILL){1'b0}}};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_hi <= '0;
            res_lo <= '0;
        end else if (load) begin
            res_hi <= hi_d;
            res_lo <= lo_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        irq_flag <= 1'b0;
        else if (load)     irq_flag <= 1'b1;
        else if (flag_clr) irq_flag <= 1'b0;
    end

endmodule

// File: rtl/sar_conv_seq.sv
module sar_conv_seq
    import sar_seq_pkg::*;
#(
    parameter int DIV_W       = 6,
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [2:0]  clk_sel,
    input  logic        rc_clk,
    input  logic        right_just,
    input  logic        go_set,
    input  logic        go_clr,
    input  logic        flag_clr,
    input  logic        cmp_in,
    output logic        go,
    output logic        sample_en,
    output logic [9:0]  dac_code,
    output logic [7:0]  res_hi,
    output logic [7:0]  res_lo,
    output logic        irq_flag
);

    logic             tick;
    logic             load;
    logic [RES_W-1:0] load_data;

    sar_tad_gen #(
        .DIV_W      (DIV_W),
        .SYNC_STAGES(SYNC_STAGES)
    ) u_tad (
        .clk   (clk),
        .rst_n (rst_n),
        .sel   (clk_sel),
        .rc_clk(rc_clk),
        .tick  (tick)
    );

    sar_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .go_set   (go_set),
        .go_clr   (go_clr),
        .cmp_in   (cmp_in),
        .busy     (go),
        .sample_en(sample_en),
        .dac_code (dac_code),
        .load     (load),
        .load_data(load_data)
    );

    sar_result_fmt u_fmt (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .load_data (load_data),
        .right_just(right_just),
        .flag_clr  (flag_clr),
        .res_hi    (res_hi),
        .res_lo    (res_lo),
        .irq_flag  (irq_flag)
    );

endmodule

// File: rtl/sar_conv_seq_chk.sv
module sar_conv_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       go_clr,
    input logic       flag_clr,
    input logic       go,
    input logic       sample_en,
    input logic [9:0] dac_code,
    input logic [7:0] res_hi,
    input logic [7:0] res_lo,
    input logic       irq_flag
);

    a_r4_switch_open_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        sample_en == !go);

    a_r5_dac_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !go |-> (dac_code == 10'd0));

    a_r6_done_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(go) && !$past(go_clr)) |-> irq_flag);

    a_r9_results_only_on_done: assert property (@(posedge clk) disable iff (!rst_n)
        !$fell(go) |-> ($stable(res_hi) && $stable(res_lo)));

    a_r9_abort_no_flag: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(go) && $past(go_clr)) |-> ($stable(irq_flag) && $stable(res_hi) && $stable(res_lo)));

    a_r10_flag_rise_on_done: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_flag) |-> $fell(go));

    a_r10_flag_fall_on_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_flag) |-> $past(flag_clr));

endmodule

bind sar_conv_seq sar_conv_seq_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .go_clr   (go_clr),
    .flag_clr (flag_clr),
    .go       (go),
    .sample_en(sample_en),
    .dac_code (dac_code),
    .res_hi   (res_hi),
    .res_lo   (res_lo),
    .irq_flag (irq_flag)
);

// File: tb/sar_conv_seq_bench.sv
`timescale 1ns/1ps
module sar_conv_seq_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] clk_sel = 3'b000;
    logic       rc_clk = 1'b0;
    logic       right_just = 1'b1;
    logic       go_set = 1'b0;
    logic       go_clr = 1'b0;
    logic       flag_clr = 1'b0;
    logic       cmp_in;
    logic       go, sample_en, irq_flag;
    logic [9:0] dac_code;
    logic [7:0] res_hi, res_lo;
    logic [9:0] vin = 10'd0;
    bit         rc_run = 1'b0;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    // ideal comparator: 1 when the analog input is at or above the DAC word
    always_comb cmp_in = (vin >= dac_code);

    // RC clock: toggles every 5 system cycles, period 10
    initial begin
        forever begin
            repeat (5) @(negedge clk);
            if (rc_run) rc_clk = ~rc_clk;
        end
    end

    sar_conv_seq u_sar_conv_seq (
        .clk(clk), .rst_n(rst_n), .clk_sel(clk_sel), .rc_clk(rc_clk),
        .right_just(right_just), .go_set(go_set), .go_clr(go_clr),
        .flag_clr(flag_clr), .cmp_in(cmp_in), .go(go), .sample_en(sample_en),
        .dac_code(dac_code), .res_hi(res_hi), .res_lo(res_lo), .irq_flag(irq_flag)
    );

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    endtask

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int ratio_of(input logic [2:0] s);
        if (s[1:0] == 2'b11) return 10;
        return 2 ** (2 * int'(s[1:0]) + 1 + int'(s[2]));
    endfunction

    function automatic logic [15:0] fmt(input logic [9:0] r, input bit rj);
        if (rj) return {6'b0, r[9:8], r[7:0]};
        return {r[9:2], r[1:0], 6'b0};
    endfunction

    int         dur;
    bit         sw_bad;
    bit         dac_bad;
    logic [7:0] hi_s, lo_s;
    bit         flag_s, sw_s;

    task automatic run_conv(input logic [9:0] v, input logic [2:0] s, input bit rj,
                            input bit poke);
        @(negedge clk);
        vin = v; clk_sel = s; right_just = rj; flag_clr = 1'b1;
        @(negedge clk);
        flag_clr = 1'b0; go_set = 1'b1;
        @(negedge clk);
        go_set = 1'b0;
        dur = 0; sw_bad = 1'b0; dac_bad = 1'b0;
        while (go && dur < 3000) begin
            dur++;
            if (sample_en) sw_bad = 1'b1;
            if (poke) go_set = (dur == 5);
            @(negedge clk);
        end
        go_set = 1'b0;
        hi_s = res_hi; lo_s = res_lo; flag_s = irq_flag; sw_s = sample_en;
        if (dac_code != 10'd0) dac_bad = 1'b1;
    endtask

    task automatic check_result(input logic [9:0] v, input bit rj, input string req);
        logic [15:0] e;
        e = fmt(v, rj);
        check({hi_s, lo_s} == e, req, int'({hi_s, lo_s}), int'(e));
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        summary();
    end

    initial begin
        // R12 reset state
        repeat (3) @(negedge clk);
        check(go == 0 && sample_en == 1 && irq_flag == 0, "R12 ctrl", int'({go, sample_en, irq_flag}), 3'b010);
        check(dac_code == 0 && res_hi == 0 && res_lo == 0, "R12 data", int'({res_hi, res_lo}), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R5 R7 R3 R6: every code, divide by 2, right-justified
        for (int v = 0; v < 1024; v++) begin
            run_conv(10'(v), 3'b000, 1'b1, 1'b0);
            check_result(10'(v), 1'b1, "R5 R7 sweep");
            if (v % 64 == 0) begin
                check(dur >= 23 && dur <= 24, "R3 div2 length", dur, 23);
                check(!sw_bad && sw_s, "R4 switch", int'({sw_bad, sw_s}), 1);
                check(flag_s, "R6 flag at done", int'(flag_s), 1);
                check(!dac_bad, "R5 dac idle", int'(dac_code), 0);
            end
        end

        // R8: left-justified, divide by 4
        for (int v = 0; v < 1024; v += 37) begin
            run_conv(10'(v), 3'b100, 1'b0, 1'b0);
            check_result(10'(v), 1'b0, "R8 left");
            check(dur >= 45 && dur <= 48, "R1 div4 length", dur, 45);
        end
        run_conv(10'h3FF, 3'b100, 1'b0, 1'b0);
        check_result(10'h3FF, 1'b0, "R8 full scale");

        // R1 R2 R3: every select code
        for (int s = 0; s < 8; s++) begin
            int p;
            p = ratio_of(3'(s));
            rc_run = (s[1:0] == 2'b11);
            run_conv(10'h1A5 + 10'(s), 3'(s), 1'b1, 1'b0);
            check(dur >= 11 * p + 1 && dur <= 12 * p,
                  (s[1:0] == 2'b11) ? "R2 rc length" : "R1 R3 select length", dur, 11 * p + 1);
            check_result(10'h1A5 + 10'(s), 1'b1, "R2 R5 select result");
            check(!sw_bad && sw_s, "R4 switch select", int'({sw_bad, sw_s}), 1);
        end
        rc_run = 1'b0;

        // R11: go strobe mid-conversion is ignored
        run_conv(10'h2C3, 3'b001, 1'b1, 1'b1);
        check(dur >= 89 && dur <= 96, "R11 no restart", dur, 89);
        check_result(10'h2C3, 1'b1, "R11 result");

        // R9: abort keeps results, no flag
        run_conv(10'h0F0, 3'b000, 1'b1, 1'b0);
        @(negedge clk);
        flag_clr = 1'b1;
        @(negedge clk);
        flag_clr = 1'b0; vin = 10'h155; go_set = 1'b1;
        @(negedge clk);
        go_set = 1'b0;
        repeat (8) @(negedge clk);
        check(go == 1 && sample_en == 0, "R9 running", int'(go), 1);
        go_clr = 1'b1;
        @(negedge clk);
        go_clr = 1'b0;
        check(go == 0 && sample_en == 1, "R9 abort idle", int'({go, sample_en}), 1);
        check(irq_flag == 0, "R9 abort flag", int'(irq_flag), 0);
        check({res_hi, res_lo} == 16'h00F0, "R9 abort result kept", int'({res_hi, res_lo}), 16'h00F0);
        repeat (40) @(negedge clk);
        check(go == 0 && irq_flag == 0, "R9 stays idle", int'({go, irq_flag}), 0);

        // R10: flag holds until cleared
        run_conv(10'h321, 3'b000, 1'b1, 1'b0);
        repeat (20) @(negedge clk);
        check(irq_flag == 1, "R10 flag holds", int'(irq_flag), 1);
        flag_clr = 1'b1;
        @(negedge clk);
        flag_clr = 1'b0;
        check(irq_flag == 0, "R10 flag cleared", int'(irq_flag), 0);

        summary();
    end

endmodule